// File: doc/BRIEF.md
# Serial Clock and Inter-Word Gap Generator

This block sits between a serial shift engine and the pins of a synchronous serial port. It divides the source clock down to a serial clock, applies the idle polarity and tells the shift engine, one source cycle at a time, when to launch the next bit and when to capture an incoming bit. After the final edge of every word it holds the serial clock at its idle level for a programmable number of source cycles. Only then does it signal that a new word may begin.

A word starts when the shift engine raises `word_start` while `word_ready` is high. In that cycle the block captures the prescale, interval, word length, polarity and phase inputs. They then stay fixed until the word and its trailing gap are complete. Each half period of the serial clock lasts `prescale+1` source cycles, so the serial rate is the source rate divided by `2*(prescale+1)`. The gap lasts `4*interval+10` source cycles, with the interval held to the usable window of 14 to 130 cycles.

Top module: `spi_sclk_gap_gen`

## Requirements
- R1: After reset `word_ready` is 1, `shift_en` and `sample_en` are 0, and `sclk` equals `cpol`.
- R2: During a word `sclk` toggles every `prescale+1` source cycles. The first toggle comes `prescale+1` cycles after the accepting edge, so the serial clock period is `2*(prescale+1)` source cycles.
- R3: Whenever no bit is being shifted, including the whole gap, `sclk` rests at its idle level: 0 when polarity is 0 and 1 when polarity is 1.
- R4: With `cpha`=0, `sample_en` pulses on each odd-numbered (leading) clock edge. `shift_en` pulses on each even-numbered (trailing) edge except the last edge of the word.
- R5: With `cpha`=1, `shift_en` pulses on each leading edge and `sample_en` pulses on each trailing edge, including the last one.
- R6: A word of `word_bits` bits produces exactly `2*word_bits` clock edges. A value of 0 acts as 1, and values above MAX_BITS (32) act as MAX_BITS.
- R7: `word_ready` rises exactly `4*interval+10` source cycles after the cycle in which the last clock edge of a word appears.
- R8: The interval is clamped to the range 1 to 30, so the gap is never shorter than 14 or longer than 130 source cycles.
- R9: After a word is accepted, changes on `prescale`, `interval`, `word_bits`, `cpol` and `cpha` have no effect until the next word is accepted. The one exception is `cpol`, which sets the idle level once `word_ready` is high again.
- R10: `word_start` is ignored while `word_ready` is low. `word_ready` falls in the cycle after a word is accepted.
- R11: `shift_en` and `sample_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale | input | PRE_W (8) | Half-period length minus one, in source cycles |
| interval | input | IV_W (5) | Gap setting; gap = 4*interval+10 source cycles after clamping |
| word_bits | input | $clog2(MAX_BITS+1) (6) | Bits in the next word |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: capture on leading edge; 1: launch on leading edge |
| word_start | input | 1 | Request to begin a word, accepted while word_ready is high |
| sclk | output | 1 | Serial clock |
| shift_en | output | 1 | One-cycle pulse: launch the next transmit bit |
| sample_en | output | 1 | One-cycle pulse: capture a receive bit |
| word_ready | output | 1 | High when a new word may be started |

## Verification
The accepting edge is counted as cycle 0. The k-th serial clock edge, together with its `shift_en` or `sample_en` pulse, becomes visible k*(prescale+1) cycles later, because the edge register and the pulse registers update on the same source edge. `word_ready` is due 4*interval+10 cycles after the final edge. The bench samples every output at the falling clock edge following each rising edge and compares it with a model indexed by that cycle count. While the word runs, the bench scrambles the captured inputs and injects spurious start requests, so the checks also show that these are ignored.

// File: rtl/sgen_pkg.sv
// Shared types and gap arithmetic for the serial clock / word-gap generator.
// Assumes the gap formula 4*interval+10 and a usable window of 14..130 cycles.
package sgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } sgen_state_e;

    localparam int GAP_BASE = 10;
    localparam int GAP_STEP = 4;
    localparam int GAP_MIN  = 14;
    localparam int GAP_MAX  = 130;
    localparam int IV_MIN   = (GAP_MIN - GAP_BASE + GAP_STEP - 1) / GAP_STEP;
    localparam int IV_MAX   = (GAP_MAX - GAP_BASE) / GAP_STEP;
    localparam int GAP_W    = $clog2(GAP_MAX + 1);

    // Clamp an interval setting to the usable window and convert it to cycles.
    function automatic logic [GAP_W-1:0] gap_cycles(input int iv);
        int c;
        c = (iv < IV_MIN) ? IV_MIN : ((iv > IV_MAX) ? IV_MAX : iv);
        return GAP_W'(GAP_STEP * c + GAP_BASE);
    endfunction

endpackage

// File: rtl/sgen_divider.sv
// Half-period divider: while run is high, tick pulses once every pre+1 cycles.
// Assumes pre is held stable while run is high; the count clears when run is low.
module sgen_divider #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    // Count source cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == pre) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == pre);
endmodule

// File: rtl/sgen_edge_map.sv
// Maps a serial clock edge onto launch and capture strobes for the selected phase.
// Assumes lead marks the first edge of a bit and last marks the final edge of the word.
module sgen_edge_map (
    input  logic tick,
    input  logic lead,
    input  logic last,
    input  logic pha,
    output logic launch,
    output logic capture
);
    // Phase 0 captures on leading edges; phase 1 launches on leading edges.
    always_comb begin
        if (pha) begin
            launch  = tick && lead;
            capture = tick && !lead;
        end else begin
            launch  = tick && !lead && !last;
            capture = tick && lead;
        end
    end
endmodule

// File: rtl/sgen_gap_timer.sv
// Inter-word gap timer: done pulses in the len-th cycle of run.
// Assumes len >= 1 and stays stable while run is high.
module sgen_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [GAP_W-1:0] len,
    output logic             done
);
    logic [GAP_W-1:0] cnt_q;

    // Count source cycles spent in the gap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == len - 1'b1);
endmodule

// File: rtl/spi_sclk_gap_gen.sv
// Serial clock and inter-word gap generator.
// Divides the source clock to src/(2*(prescale+1)), applies polarity and phase,
// strobes launch/capture per edge and enforces a 4*interval+10 cycle gap
// after each word. All settings are captured when a word is accepted.
module spi_sclk_gap_gen #(
    parameter int PRE_W    = 8,
    parameter int IV_W     = 5,
    parameter int MAX_BITS = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PRE_W-1:0]                prescale,
    input  logic [IV_W-1:0]                 interval,
    input  logic [$clog2(MAX_BITS+1)-1:0]   word_bits,
    input  logic                            cpol,
    input  logic                            cpha,
    input  logic                            word_start,
    output logic                            sclk,
    output logic                            shift_en,
    output logic                            sample_en,
    output logic                            word_ready
);
    import sgen_pkg::*;

    localparam int BITS_W = $clog2(MAX_BITS + 1);
    localparam int EDGE_W = $clog2(2 * MAX_BITS + 1);

    sgen_state_e        state_q;
    logic [PRE_W-1:0]   pre_q;
    logic [GAP_W-1:0]   gap_q;
    logic [EDGE_W-1:0]  nedge_q;
    logic [EDGE_W-1:0]  edge_cnt_q;
    logic               pol_q;
    logic               pha_q;
    logic               raw_q;
    logic               shift_q;
    logic               sample_q;

    logic [BITS_W-1:0]  nbits;
    logic               accept;
    logic               tick;
    logic               lead;
    logic               last;
    logic               launch;
    logic               capture;
    logic               gap_done;

    // Clamp the requested word length to 1..MAX_BITS.
    always_comb begin
        if (word_bits == '0) begin
            nbits = BITS_W'(1);
        end else if (word_bits > BITS_W'(MAX_BITS)) begin
            nbits = BITS_W'(MAX_BITS);
        end else begin
            nbits = word_bits;
        end
    end

    assign accept = (state_q == ST_IDLE) && word_start;
    assign lead   = ~edge_cnt_q[0];
    assign last   = (EDGE_W'(edge_cnt_q + 1'b1) == nedge_q);

    sgen_divider #(.PRE_W(PRE_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SHIFT),
        .pre   (pre_q),
        .tick  (tick)
    );

    sgen_edge_map map_i (
        .tick    (tick),
        .lead    (lead),
        .last    (last),
        .pha     (pha_q),
        .launch  (launch),
        .capture (capture)
    );

    sgen_gap_timer #(.GAP_W(GAP_W)) gap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_GAP),
        .len   (gap_q),
        .done  (gap_done)
    );

    // Sequence idle -> shift -> gap -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (accept)           state_q <= ST_SHIFT;
                ST_SHIFT: if (tick && last)     state_q <= ST_GAP;
                ST_GAP:   if (gap_done)         state_q <= ST_IDLE;
                default:                        state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture per-word settings when a word is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            gap_q   <= GAP_W'(GAP_MIN);
            nedge_q <= EDGE_W'(2);
            pol_q   <= 1'b0;
            pha_q   <= 1'b0;
        end else if (accept) begin
            pre_q   <= prescale;
            gap_q   <= gap_cycles(int'(interval));
            nedge_q <= EDGE_W'({nbits, 1'b0});
            pol_q   <= cpol;
            pha_q   <= cpha;
        end
    end

    // Track the raw clock level and the number of edges issued in the word.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            raw_q      <= 1'b0;
            edge_cnt_q <= '0;
        end else if (tick) begin
            raw_q      <= ~raw_q;
            edge_cnt_q <= edge_cnt_q + 1'b1;
        end
    end

    // Register the strobes so they line up with the clock edge they belong to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= 1'b0;
            sample_q <= 1'b0;
        end else begin
            shift_q  <= launch;
            sample_q <= capture;
        end
    end

    assign sclk       = raw_q ^ ((state_q == ST_IDLE) ? cpol : pol_q);
    assign shift_en   = shift_q;
    assign sample_en  = sample_q;
    assign word_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/spi_sclk_gap_gen_chk.sv
// Port-level protocol checks for the serial clock / word-gap generator.
module spi_sclk_gap_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cpol,
    input logic word_start,
    input logic sclk,
    input logic shift_en,
    input logic sample_en,
    input logic word_ready
);
    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (sclk == cpol));

    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (!shift_en && !sample_en));

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && word_start) |=> !word_ready);

    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_en, sample_en}));

    p_strobe_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en || sample_en) |-> (sclk != $past(sclk)));
endmodule

bind spi_sclk_gap_gen spi_sclk_gap_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpol       (cpol),
    .word_start (word_start),
    .sclk       (sclk),
    .shift_en   (shift_en),
    .sample_en  (sample_en),
    .word_ready (word_ready)
);

// File: tb/spi_sclk_gap_gen_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_gap_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] prescale = '0;
    logic [4:0] interval = '0;
    logic [5:0] word_bits = '0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       word_start = 1'b0;
    logic       sclk, shift_en, sample_en, word_ready;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_sclk_gap_gen dut_i (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .interval(interval),
        .word_bits(word_bits), .cpol(cpol), .cpha(cpha), .word_start(word_start),
        .sclk(sclk), .shift_en(shift_en), .sample_en(sample_en), .word_ready(word_ready)
    );

    task automatic chk(input string req, input string sig, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, sig, act, exp, $time);
        end
    endtask

    function automatic int exp_gap(input int iv);
        int c;
        c = (iv < 1) ? 1 : ((iv > 30) ? 30 : iv);
        return 4 * c + 10;
    endfunction

    // Run one word and its gap, checking every cycle against the timing model.
    task automatic run_word(input int pre, input int iv, input int bits,
                            input bit pol, input bit pha, input string tag);
        int n, h, g, last_k, tot, ed, j;
        bit lead, pulse, pol_live, e_sclk, e_sh, e_sa, e_rdy;
        n = (bits == 0) ? 1 : ((bits > 32) ? 32 : bits);
        h = pre + 1;
        g = exp_gap(iv);
        last_k = 2 * n * h;
        tot = last_k + g;
        @(negedge clk);
        chk({tag, "/R10"}, "word_ready before start", int'(word_ready), 1);
        prescale = 8'(pre); interval = 5'(iv); word_bits = 6'(bits);
        cpol = pol; cpha = pha; word_start = 1'b1; pol_live = pol;
        @(negedge clk);
        word_start = 1'b0;
        chk({tag, "/R10"}, "word_ready after accept", int'(word_ready), 0);
        for (int k = 1; k <= tot; k++) begin
            @(negedge clk);
            if (k <= last_k) begin
                ed = k / h;
                pulse = (k % h) == 0;
                j = ed;
                lead = (j % 2) == 1;
                e_sclk = bit'(ed % 2) ^ pol;
                e_sa = pulse && (pha ? !lead : lead);
                e_sh = pulse && (pha ? lead : (!lead && j != 2 * n));
                e_rdy = 1'b0;
            end else begin
                e_sclk = (k >= tot) ? pol_live : pol;
                e_sa = 1'b0;
                e_sh = 1'b0;
                e_rdy = (k >= tot);
            end
            chk({tag, (k <= last_k) ? "/R2" : "/R3"}, "sclk", int'(sclk), int'(e_sclk));
            chk({tag, pha ? "/R5" : "/R4"}, "shift_en", int'(shift_en), int'(e_sh));
            chk({tag, pha ? "/R5" : "/R4"}, "sample_en", int'(sample_en), int'(e_sa));
            chk({tag, "/R7"}, "word_ready", int'(word_ready), int'(e_rdy));
            chk({tag, "/R11"}, "strobe overlap", int'(shift_en && sample_en), 0);
            // Scramble captured settings and inject ignored start requests (R9, R10).
            prescale = 8'($urandom); interval = 5'($urandom);
            word_bits = 6'($urandom); cpha = 1'($urandom);
            word_start = (k < last_k) && (k % 3 == 0);
            if (k == last_k) begin
                cpol = 1'($urandom);
                pol_live = cpol;
            end
        end
        word_start = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("R1", "word_ready in reset", int'(word_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "word_ready", int'(word_ready), 1);
        chk("R1", "shift_en", int'(shift_en), 0);
        chk("R1", "sample_en", int'(sample_en), 0);
        chk("R1", "sclk idle low", int'(sclk), 0);
        cpol = 1'b1;
        @(negedge clk);
        chk("R1", "sclk idle high", int'(sclk), 1);

        run_word(0, 0, 8, 1'b0, 1'b0, "R8");
        run_word(3, 31, 5, 1'b1, 1'b1, "R8");
        run_word(0, 1, 3, 1'b1, 1'b0, "R8");
        run_word(1, 30, 2, 1'b0, 1'b1, "R8");
        run_word(0, 4, 0, 1'b0, 1'b1, "R6");
        run_word(1, 2, 40, 1'b1, 1'b0, "R6");
        run_word(0, 3, 32, 1'b0, 1'b1, "R6");
        run_word(7, 7, 4, 1'b0, 1'b0, "R9");
        for (int w = 0; w < 40; w++) begin
            run_word(int'($urandom_range(0, 4)), int'($urandom_range(0, 31)),
                     int'($urandom_range(0, 12)), 1'($urandom), 1'($urandom), "R10");
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule